// File: doc/BRIEF.md
# Charge-Pump Fastlock Timer Controller

This block picks the charge-pump current code while a synthesizer changes frequency. It keeps the boost-gain bit that arrives with each divider-latch write. While that bit is set and fastlock is switched on, the block outputs a boost current code. Otherwise it outputs the static current code. A fastlock-active flag is output beside the code.

Two exit policies are available. In manual mode the boost stays on until a later divider-latch write carries a zero gain bit. In timed mode a countdown measured in phase-detector events clears the stored gain bit by itself. The countdown then returns the output to the static code. Power-down holds the countdown at its load value and does not change the stored gain bit.

Top module: `cp_fastlock_ctrl`

## Requirements
- R1: While `fl_enable` is 0, `fastlock_active` is 0 and `cur_code` equals `cur_static`, whatever the stored gain bit is.
- R2: `fastlock_active` is 1 exactly when `fl_enable` is 1 and the stored gain bit is 1. The stored gain bit is kept while `fl_enable` is 0.
- R3: `cur_code` equals `cur_boost` while `fastlock_active` is 1 and `cur_static` otherwise.
- R4: A cycle with `gain_wr`=1 and `gain_wdata`=1 sets the stored gain bit on that clock edge, in either mode.
- R5: In manual mode (`fl_mode2`=0), phase-detector ticks never clear the stored gain bit. Only a write with `gain_wdata`=0 clears it.
- R6: In timed mode (`fl_mode2`=1, enabled), the stored gain bit clears on the edge that takes the Nth `pfd_tick` after the setting write, with N = 3 + 4 × `timeout_code` (3 to 63). The bit stays set after N-1 ticks.
- R7: A write of 1 while the countdown runs reloads it, so a full N further ticks are needed. This holds also when the write coincides with the final tick.
- R8: The countdown advances only while timed mode is selected, fastlock is enabled and the gain bit is set. Ticks taken in manual mode do not shorten a later timed run.
- R9: While `power_down` is 1 the countdown is held at its load value and the stored gain bit is unchanged. After release a full N ticks are needed.
- R10: A write with `gain_wdata`=0 clears the stored gain bit in timed mode too.
- R11: After reset the stored gain bit is 0, so `fastlock_active` is 0 and `cur_code` equals `cur_static`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fl_enable | input | 1 | Fastlock master enable |
| fl_mode2 | input | 1 | 0 manual exit, 1 timed exit |
| timeout_code | input | 4 | Timeout selector, N = 3 + 4 × code ticks |
| cur_static | input | 3 | Current code for steady state |
| cur_boost | input | 3 | Current code during fastlock |
| gain_wr | input | 1 | One-cycle strobe: divider latch written |
| gain_wdata | input | 1 | Gain bit carried by that write |
| pfd_tick | input | 1 | One-cycle phase-detector event strobe |
| power_down | input | 1 | Power-down request, holds the countdown |
| cur_code | output | 3 | Current code in effect |
| fastlock_active | output | 1 | High while the boost current applies |

## Verification
On every cycle the assertions check four things: the enable gating, the choice between the boost and static codes, and that a manual-mode gain bit holds without a write. They also check the countdown range and that the countdown is held during power-down or when idle. The exact tick count to expiry for several timeout codes can only be shown by the bench scenarios. The same holds for reload on a rewrite, including one that collides with the final tick, for switching from manual to timed mode, and for resuming after power-down.

// File: rtl/fl_pkg.sv
package fl_pkg;
    localparam int CODE_W   = 3;
    localparam int TC_W     = 4;
    localparam int TMO_BASE = 3;
    localparam int TMO_STEP = 4;
    localparam int LOAD_MAX = TMO_BASE + TMO_STEP * ((1 << TC_W) - 1);
    localparam int CNT_W    = $clog2(LOAD_MAX + 1);

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [TC_W-1:0]   tc_t;
    typedef logic [CODE_W-1:0] icode_t;

    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_TIMED  = 1'b1
    } fl_mode_e;

    typedef struct packed {
        logic     enable;
        fl_mode_e mode;
    } fl_cfg_t;

    function automatic cnt_t tmo_load(tc_t code);
        return cnt_t'(TMO_BASE) + cnt_t'(TMO_STEP) * cnt_t'(code);
    endfunction
endpackage

// File: rtl/fl_gain_state.sv
module fl_gain_state (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wdata,
    input  logic expire,
    output logic gain_q
);
    always_ff @(posedge clk) begin
        if (rst)         gain_q <= 1'b0;
        else if (wr)     gain_q <= wdata;   // explicit write wins over expiry
        else if (expire) gain_q <= 1'b0;
    end

    assert_write_one_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata) |=> gain_q);
    assert_write_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata) |=> !gain_q);
endmodule

// File: rtl/fl_timeout_timer.sv
module fl_timeout_timer
    import fl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic restart,
    input  logic pd,
    input  tc_t  code,
    output logic expire
);
    cnt_t cnt_q;
    cnt_t load_val;

    assign load_val = tmo_load(code);
    assign expire   = run && tick && !pd && !restart && (cnt_q == cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst || pd || restart || !run) cnt_q <= load_val;
        else if (tick)                    cnt_q <= (cnt_q == cnt_t'(1)) ? load_val : cnt_q - cnt_t'(1);
    end

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) && (int'(cnt_q) <= LOAD_MAX));
    assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && !pd && !restart) |=> $stable(cnt_q));
    assert_pd_load_R9: assert property (@(posedge clk) disable iff (rst)
        pd |=> (cnt_q == $past(load_val)));
    assert_idle_load_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/fl_cur_mux.sv
module fl_cur_mux
    import fl_pkg::*;
(
    input  logic   boost_on,
    input  icode_t set_static,
    input  icode_t set_boost,
    output icode_t code_out
);
    assign code_out = boost_on ? set_boost : set_static;
endmodule

// File: rtl/cp_fastlock_ctrl.sv
module cp_fastlock_ctrl
    import fl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fl_enable,
    input  logic              fl_mode2,
    input  logic [TC_W-1:0]   timeout_code,
    input  logic [CODE_W-1:0] cur_static,
    input  logic [CODE_W-1:0] cur_boost,
    input  logic              gain_wr,
    input  logic              gain_wdata,
    input  logic              pfd_tick,
    input  logic              power_down,
    output logic [CODE_W-1:0] cur_code,
    output logic              fastlock_active
);
    fl_cfg_t cfg;
    logic    gain_q;
    logic    expire;
    logic    timer_run;

    assign cfg.enable = fl_enable;
    assign cfg.mode   = fl_mode_e'(fl_mode2);

    assign timer_run       = cfg.enable && (cfg.mode == MODE_TIMED) && gain_q;
    assign fastlock_active = cfg.enable && gain_q;

    fl_gain_state u_gain (
        .clk    (clk),
        .rst    (rst),
        .wr     (gain_wr),
        .wdata  (gain_wdata),
        .expire (expire),
        .gain_q (gain_q)
    );

    fl_timeout_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (timer_run),
        .tick    (pfd_tick),
        .restart (gain_wr),
        .pd      (power_down),
        .code    (timeout_code),
        .expire  (expire)
    );

    fl_cur_mux u_mux (
        .boost_on   (fastlock_active),
        .set_static (cur_static),
        .set_boost  (cur_boost),
        .code_out   (cur_code)
    );

    assert_disabled_static_R1: assert property (@(posedge clk) disable iff (rst)
        !fl_enable |-> (!fastlock_active && cur_code == cur_static));
    assert_boost_select_R3: assert property (@(posedge clk) disable iff (rst)
        fastlock_active |-> (cur_code == cur_boost));
    assert_manual_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (gain_q && fl_enable && !fl_mode2 && !gain_wr) |=> gain_q);
    assert_pd_keeps_gain_R9: assert property (@(posedge clk) disable iff (rst)
        (gain_q && power_down && !gain_wr) |=> gain_q);
endmodule

// File: tb/cp_fastlock_ctrl_bench.sv
module cp_fastlock_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       fl_enable, fl_mode2, gain_wr, gain_wdata, pfd_tick, power_down;
    logic [3:0] timeout_code;
    logic [2:0] cur_static, cur_boost, cur_code;
    logic       fastlock_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cp_fastlock_ctrl u_cp_fastlock_ctrl (
        .clk(clk), .rst(rst), .fl_enable(fl_enable), .fl_mode2(fl_mode2),
        .timeout_code(timeout_code), .cur_static(cur_static), .cur_boost(cur_boost),
        .gain_wr(gain_wr), .gain_wdata(gain_wdata), .pfd_tick(pfd_tick),
        .power_down(power_down), .cur_code(cur_code), .fastlock_active(fastlock_active)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_gain(logic v);
        @(negedge clk); gain_wr = 1'b1; gain_wdata = v;
        @(negedge clk); gain_wr = 1'b0; gain_wdata = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pfd_tick = 1'b1;
            @(negedge clk); pfd_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk("R11 active after reset", fastlock_active, 0);
        chk("R11 code after reset", cur_code, cur_static);
    endtask

    task automatic t_disabled;
        fl_enable = 1'b0; fl_mode2 = 1'b0;
        write_gain(1'b1);
        chk("R1 active while disabled", fastlock_active, 0);
        chk("R1 code while disabled", cur_code, cur_static);
        @(negedge clk); fl_enable = 1'b1;
        #1;
        chk("R2 stored gain shows on enable", fastlock_active, 1);
        chk("R3 boost code", cur_code, cur_boost);
        write_gain(1'b0);
    endtask

    task automatic t_manual;
        fl_enable = 1'b1; fl_mode2 = 1'b0; timeout_code = 4'd0;
        write_gain(1'b1);
        chk("R4 entry manual", fastlock_active, 1);
        ticks(80);
        chk("R5 ticks ignored in manual", fastlock_active, 1);
        write_gain(1'b0);
        chk("R5 exit by write 0", fastlock_active, 0);
        chk("R3 static code after exit", cur_code, cur_static);
    endtask

    task automatic t_timed(logic [3:0] c);
        int n = 3 + 4 * int'(c);
        fl_enable = 1'b1; fl_mode2 = 1'b1; timeout_code = c;
        write_gain(1'b1);
        chk("R4 entry timed", fastlock_active, 1);
        ticks(n - 1);
        chk("R6 still active at N-1", fastlock_active, 1);
        ticks(1);
        chk("R6 cleared at N", fastlock_active, 0);
        chk("R6 static code after timeout", cur_code, cur_static);
    endtask

    task automatic t_reload;
        fl_enable = 1'b1; fl_mode2 = 1'b1; timeout_code = 4'd2; // N = 11
        write_gain(1'b1);
        ticks(8);
        write_gain(1'b1);
        ticks(10);
        chk("R7 reload keeps active", fastlock_active, 1);
        // rewrite colliding with final tick
        @(negedge clk); pfd_tick = 1'b1; gain_wr = 1'b1; gain_wdata = 1'b1;
        @(negedge clk); pfd_tick = 1'b0; gain_wr = 1'b0; gain_wdata = 1'b0;
        chk("R7 write wins over final tick", fastlock_active, 1);
        ticks(10);
        chk("R7 full period after collision", fastlock_active, 1);
        ticks(1);
        chk("R7 clears after reload period", fastlock_active, 0);
    endtask

    task automatic t_switch;
        fl_enable = 1'b1; fl_mode2 = 1'b0; timeout_code = 4'd0; // N = 3
        write_gain(1'b1);
        ticks(10);
        @(negedge clk); fl_mode2 = 1'b1;
        ticks(2);
        chk("R8 manual ticks not counted", fastlock_active, 1);
        ticks(1);
        chk("R8 timed run expires", fastlock_active, 0);
    endtask

    task automatic t_powerdown;
        fl_enable = 1'b1; fl_mode2 = 1'b1; timeout_code = 4'd1; // N = 7
        write_gain(1'b1);
        ticks(4);
        @(negedge clk); power_down = 1'b1;
        ticks(20);
        chk("R9 gain kept in power-down", fastlock_active, 1);
        @(negedge clk); power_down = 1'b0;
        ticks(6);
        chk("R9 countdown restarted", fastlock_active, 1);
        ticks(1);
        chk("R9 expires after full period", fastlock_active, 0);
    endtask

    task automatic t_clear_timed;
        fl_enable = 1'b1; fl_mode2 = 1'b1; timeout_code = 4'd15;
        write_gain(1'b1);
        ticks(5);
        write_gain(1'b0);
        chk("R10 write 0 clears in timed", fastlock_active, 0);
    endtask

    initial begin
        rst = 1'b1; fl_enable = 1'b0; fl_mode2 = 1'b0; timeout_code = 4'd0;
        cur_static = 3'd2; cur_boost = 3'd5;
        gain_wr = 1'b0; gain_wdata = 1'b0; pfd_tick = 1'b0; power_down = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_manual();
        t_timed(4'd0);
        t_timed(4'd5);
        cur_static = 3'd7; cur_boost = 3'd1;
        t_timed(4'd15);
        t_reload();
        t_switch();
        t_powerdown();
        t_clear_timed();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule